// File: doc/BRIEF.md
# Byte-mode converter reader

This block is the host-side controller for a 12-bit successive-approximation converter that talks over an 8-bit parallel bus. A single start request makes it run a whole transaction on the converter bus. When asked, it first writes a 12-bit control value as two bytes. It then drops the conversion-start line for a set number of clocks and waits for the converter's busy line to rise and then fall. After that it reads the result back as two bytes and delivers the assembled sample on its output side.

The two reads are distinguished by a high-byte select line. The low read carries result bits 7:0. The high read carries result bits 11:8 in its low nibble, the 2-bit channel number in bits 5:4, and two reserved bits in 7:6 that should read as zero. The controller merges both reads into a 12-bit result and a channel number. It marks the sample with a one-cycle valid pulse, and it flags reserved bits that are not zero. The length of every bus strobe and the longest wait allowed for busy are set by inputs. These values are captured when a transaction starts. If busy never completes, the transaction is abandoned and a timeout is reported.

Top module: `adc_byte_reader`

## Requirements
- R1: After reset, the conversion-start, chip-select, read and write lines are all high (inactive), the high-byte select is low, valid, reserved-error and timeout are low, and the result and channel outputs are zero.
- R2: A start request accepted while idle drives the conversion-start line low for exactly W consecutive clocks. W is the strobe length input captured at the start, and a value of 0 counts as 1. Chip select stays high while conversion-start is low.
- R3: No read strobe is issued until the busy line has been seen to rise and then fall after the conversion-start pulse, and the read line is never low while busy is high.
- R4: After busy falls, exactly two read strobes follow, with at least one clock between them. The first has the high-byte select low and the second has it high. In each one, chip select and read are low together for exactly W clocks, and the data bus is sampled on the last of those clocks.
- R5: The result output equals {high byte bits 3:0, low byte bits 7:0}, and the channel output equals high byte bits 5:4.
- R6: Each completed transaction produces valid high for exactly one clock. The result and channel outputs change only in the clock where valid is high, and otherwise hold their value.
- R7: If bits 7:6 of the high-byte read are not both zero, the reserved-error output is high in the same clock as valid, and the result and channel are still delivered. Otherwise it stays low.
- R8: If busy has not completed its rise and fall within the busy-limit input's number of clocks of waiting, the transaction is abandoned. Timeout pulses high for one clock, no read strobe and no valid pulse occur, and the result output keeps its previous value.
- R9: When the control-write request is high with the start request, two write strobes of W clocks each precede the conversion-start pulse. The first has the high-byte select low and drives control bits 7:0. The second has it high and drives {4'b0000, control bits 11:8}. The data-bus drive enable is high only while a write strobe is active.
- R10: Start requests that arrive while a transaction is in progress are ignored, so each transaction produces exactly one conversion-start pulse.
- R11: Read and write are never low in the same clock, and chip select is low whenever either one is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Transaction request, sampled while idle |
| cfg_wr_i | input | 1 | Write the control value before converting (sampled with start_i) |
| cfg_word_i | input | 12 | Control value to write |
| strobe_len_i | input | 6 | Strobe length W in clocks (0 is treated as 1) |
| busy_limit_i | input | 16 | Longest wait for busy to complete, in clocks |
| adc_busy_i | input | 1 | Converter busy line (asynchronous, synchronized inside) |
| adc_data_i | input | 8 | Data bus from the converter |
| adc_data_o | output | 8 | Data bus toward the converter during writes |
| adc_data_oe_o | output | 1 | Drive enable for adc_data_o |
| adc_cs_n_o | output | 1 | Chip select, active low |
| adc_rd_n_o | output | 1 | Read strobe, active low |
| adc_wr_n_o | output | 1 | Write strobe, active low |
| adc_convst_n_o | output | 1 | Conversion start, active low |
| adc_hben_o | output | 1 | High-byte select |
| result_o | output | 12 | Assembled conversion result |
| chan_o | output | 2 | Channel number from the high byte |
| valid_o | output | 1 | One-clock pulse when a new result is presented |
| rsv_err_o | output | 1 | Reserved high-byte bits were nonzero (with valid_o) |
| timeout_o | output | 1 | One-clock pulse when busy did not complete in time |

## Verification
The hardest case to reach is the abandonment path. The wait has to run out both before busy ever rises and while busy is stuck high. After that, the next transaction still has to behave normally, and the earlier result must stay on the outputs. The bench gets there with a behavioural converter model that has three busy modes: normal, never rising, and stuck high. It then releases the stuck line and runs a clean conversion to confirm the controller has recovered. Reserved-bit errors and start requests that arrive mid-transaction are injected through the same model. These sit alongside a sweep over strobe lengths 0 to 4, sixteen result patterns covering all four channel numbers, and varied busy durations.

// File: rtl/adc_rdr_pkg.sv
package adc_rdr_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WR_LO,
      ST_WR_GAP,
      ST_WR_HI,
      ST_CV_GAP,
      ST_CONV,
      ST_WAIT_HI,
      ST_WAIT_LO,
      ST_RD_LO,
      ST_RD_GAP,
      ST_RD_HI,
      ST_DONE
   } rdr_state_e;

   // Registered view of the converter bus control lines.
   typedef struct packed {
      logic cs_n;
      logic rd_n;
      logic wr_n;
      logic convst_n;
      logic hben;
      logic drive;
   } bus_ctl_t;

   localparam bus_ctl_t BUS_QUIET = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                      convst_n: 1'b1, hben: 1'b0, drive: 1'b0};

   function automatic bus_ctl_t decode_bus(input rdr_state_e s);
      bus_ctl_t b;
      b = BUS_QUIET;
      case (s)
         ST_WR_LO: begin b.cs_n = 1'b0; b.wr_n = 1'b0; b.drive = 1'b1; end
         ST_WR_HI: begin b.cs_n = 1'b0; b.wr_n = 1'b0; b.drive = 1'b1; b.hben = 1'b1; end
         ST_CONV:  begin b.convst_n = 1'b0; end
         ST_RD_LO: begin b.cs_n = 1'b0; b.rd_n = 1'b0; end
         ST_RD_HI: begin b.cs_n = 1'b0; b.rd_n = 1'b0; b.hben = 1'b1; end
         default:  b = BUS_QUIET;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/adc_rdr_sync.sv
module adc_rdr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 0) begin : g_bad_stages
         $error("adc_rdr_sync: STAGES must not be negative");
      end

      if (STAGES == 0) begin : g_direct
         assign q_o = d_i;
      end else if (STAGES == 1) begin : g_single
         logic ff_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= 1'b0;
            else        ff_q <= d_i;
         end
         assign q_o = ff_q;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-2:0], d_i};
         end
         assign q_o = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/adc_rdr_strobe.sv
module adc_rdr_strobe #(
   parameter int LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             last_o
);

   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] eff_len;

   // A zero length still produces a one-clock strobe.
   assign eff_len = (len_i == '0) ? LEN_W'(1) : len_i;
   assign last_o  = run_i && (cnt_q == eff_len - LEN_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!run_i || last_o) cnt_q <= '0;
      else                       cnt_q <= cnt_q + LEN_W'(1);
   end

endmodule

// File: rtl/adc_rdr_wdog.sv
module adc_rdr_wdog #(
   parameter int LIM_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [LIM_W-1:0] limit_i,
   output logic             expired_o
);

   logic [LIM_W-1:0] cnt_q;

   assign expired_o = run_i && (cnt_q >= limit_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run_i)        cnt_q <= '0;
      else if (cnt_q != '1)   cnt_q <= cnt_q + LIM_W'(1);
   end

endmodule

// File: rtl/adc_rdr_pack.sv
module adc_rdr_pack #(
   parameter int DATA_W = 8,
   parameter int RES_W  = 12,
   parameter int ID_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_lo_i,
   input  logic              cap_hi_i,
   input  logic              publish_i,
   input  logic [DATA_W-1:0] byte_i,
   output logic [RES_W-1:0]  result_o,
   output logic [ID_W-1:0]   chan_o,
   output logic              valid_o,
   output logic              rsv_err_o
);

   localparam int HI_BITS = RES_W - DATA_W;
   localparam int RSV_LSB = HI_BITS + ID_W;

   logic [DATA_W-1:0] lo_q;
   logic [DATA_W-1:0] hi_q;
   logic              rsv_bad;

   generate
      if (RSV_LSB < DATA_W) begin : g_rsv
         assign rsv_bad = |hi_q[DATA_W-1:RSV_LSB];
      end else begin : g_no_rsv
         assign rsv_bad = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         if (cap_lo_i) lo_q <= byte_i;
         if (cap_hi_i) hi_q <= byte_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o  <= '0;
         chan_o    <= '0;
         valid_o   <= 1'b0;
         rsv_err_o <= 1'b0;
      end else begin
         valid_o   <= publish_i;
         rsv_err_o <= publish_i && rsv_bad;
         if (publish_i) begin
            result_o <= {hi_q[HI_BITS-1:0], lo_q};
            chan_o   <= hi_q[RSV_LSB-1:HI_BITS];
         end
      end
   end

endmodule

// File: rtl/adc_byte_reader.sv
module adc_byte_reader #(
   parameter int DATA_W      = 8,
   parameter int RES_W       = 12,
   parameter int ID_W        = 2,
   parameter int STRB_W      = 6,
   parameter int TMO_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              cfg_wr_i,
   input  logic [RES_W-1:0]  cfg_word_i,
   input  logic [STRB_W-1:0] strobe_len_i,
   input  logic [TMO_W-1:0]  busy_limit_i,
   input  logic              adc_busy_i,
   input  logic [DATA_W-1:0] adc_data_i,
   output logic [DATA_W-1:0] adc_data_o,
   output logic              adc_data_oe_o,
   output logic              adc_cs_n_o,
   output logic              adc_rd_n_o,
   output logic              adc_wr_n_o,
   output logic              adc_convst_n_o,
   output logic              adc_hben_o,
   output logic [RES_W-1:0]  result_o,
   output logic [ID_W-1:0]   chan_o,
   output logic              valid_o,
   output logic              rsv_err_o,
   output logic              timeout_o
);
   import adc_rdr_pkg::*;

   localparam int HI_BITS = RES_W - DATA_W;
   localparam int PAD_W   = DATA_W - HI_BITS;

   generate
      if (RES_W <= DATA_W) begin : g_err_res
         $error("adc_byte_reader: RES_W must exceed DATA_W");
      end
      if (HI_BITS + ID_W > DATA_W) begin : g_err_hi
         $error("adc_byte_reader: high byte cannot hold upper result bits and channel");
      end
      if (STRB_W < 1 || TMO_W < 1) begin : g_err_cnt
         $error("adc_byte_reader: counter widths must be positive");
      end
      if (SYNC_STAGES > 4) begin : g_err_sync
         $error("adc_byte_reader: SYNC_STAGES limited to 4");
      end
   endgenerate

   rdr_state_e         state_q, state_d;
   bus_ctl_t           bus_q;
   logic [STRB_W-1:0]  len_q;
   logic [TMO_W-1:0]   lim_q;
   logic [RES_W-1:0]   cfg_q;
   logic               tmo_q;

   logic busy_s;
   logic strobe_run;
   logic strobe_last;
   logic wait_run;
   logic wait_expired;
   logic cap_lo, cap_hi, publish;
   logic take_start;

   adc_rdr_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (adc_busy_i),
      .q_o   (busy_s)
   );

   assign strobe_run = (state_q == ST_WR_LO) || (state_q == ST_WR_HI) ||
                       (state_q == ST_CONV)  || (state_q == ST_RD_LO) ||
                       (state_q == ST_RD_HI);

   adc_rdr_strobe #(.LEN_W(STRB_W)) u_strobe (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (strobe_run),
      .len_i  (len_q),
      .last_o (strobe_last)
   );

   assign wait_run = (state_q == ST_WAIT_HI) || (state_q == ST_WAIT_LO);

   adc_rdr_wdog #(.LIM_W(TMO_W)) u_wdog (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (wait_run),
      .limit_i   (lim_q),
      .expired_o (wait_expired)
   );

   assign take_start = (state_q == ST_IDLE) && start_i;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:    if (start_i) state_d = cfg_wr_i ? ST_WR_LO : ST_CONV;
         ST_WR_LO:   if (strobe_last) state_d = ST_WR_GAP;
         ST_WR_GAP:  state_d = ST_WR_HI;
         ST_WR_HI:   if (strobe_last) state_d = ST_CV_GAP;
         ST_CV_GAP:  state_d = ST_CONV;
         ST_CONV:    if (strobe_last) state_d = ST_WAIT_HI;
         ST_WAIT_HI: begin
            if (busy_s)            state_d = ST_WAIT_LO;
            else if (wait_expired) state_d = ST_IDLE;
         end
         ST_WAIT_LO: begin
            if (!busy_s)           state_d = ST_RD_LO;
            else if (wait_expired) state_d = ST_IDLE;
         end
         ST_RD_LO:   if (strobe_last) state_d = ST_RD_GAP;
         ST_RD_GAP:  state_d = ST_RD_HI;
         ST_RD_HI:   if (strobe_last) state_d = ST_DONE;
         ST_DONE:    state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bus_q   <= BUS_QUIET;
         len_q   <= '0;
         lim_q   <= '0;
         cfg_q   <= '0;
         tmo_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         bus_q   <= decode_bus(state_d);
         tmo_q   <= wait_run && (state_d == ST_IDLE);
         if (take_start) begin
            len_q <= strobe_len_i;
            lim_q <= busy_limit_i;
            cfg_q <= cfg_word_i;
         end
      end
   end

   assign cap_lo  = (state_q == ST_RD_LO) && strobe_last;
   assign cap_hi  = (state_q == ST_RD_HI) && strobe_last;
   assign publish = (state_q == ST_DONE);

   adc_rdr_pack #(.DATA_W(DATA_W), .RES_W(RES_W), .ID_W(ID_W)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_lo_i  (cap_lo),
      .cap_hi_i  (cap_hi),
      .publish_i (publish),
      .byte_i    (adc_data_i),
      .result_o  (result_o),
      .chan_o    (chan_o),
      .valid_o   (valid_o),
      .rsv_err_o (rsv_err_o)
   );

   assign adc_data_o     = bus_q.hben ? {{PAD_W{1'b0}}, cfg_q[RES_W-1:DATA_W]}
                                      : cfg_q[DATA_W-1:0];
   assign adc_data_oe_o  = bus_q.drive;
   assign adc_cs_n_o     = bus_q.cs_n;
   assign adc_rd_n_o     = bus_q.rd_n;
   assign adc_wr_n_o     = bus_q.wr_n;
   assign adc_convst_n_o = bus_q.convst_n;
   assign adc_hben_o     = bus_q.hben;
   assign timeout_o      = tmo_q;

endmodule

// File: rtl/adc_rdr_checks.sv
module adc_rdr_checks #(
   parameter int DATA_W = 8,
   parameter int RES_W  = 12,
   parameter int ID_W   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              adc_busy_i,
   input logic [DATA_W-1:0] adc_data_o,
   input logic              adc_data_oe_o,
   input logic              adc_cs_n_o,
   input logic              adc_rd_n_o,
   input logic              adc_wr_n_o,
   input logic              adc_convst_n_o,
   input logic              adc_hben_o,
   input logic [RES_W-1:0]  result_o,
   input logic [ID_W-1:0]   chan_o,
   input logic              valid_o,
   input logic              rsv_err_o,
   input logic              timeout_o
);

   localparam int HI_BITS = RES_W - DATA_W;

   assert_rd_wr_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(!adc_rd_n_o && !adc_wr_n_o));

   assert_cs_covers_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!adc_rd_n_o || !adc_wr_n_o) |-> !adc_cs_n_o);

   assert_no_cs_in_conv_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_convst_n_o |-> adc_cs_n_o);

   assert_read_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_rd_n_o |-> !adc_busy_i);

   assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   assert_hold_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(result_o) && $stable(chan_o)));

   assert_err_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_err_o |-> valid_o);

   assert_tmo_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> (!valid_o && adc_rd_n_o));

   assert_drive_only_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      adc_data_oe_o |-> (adc_rd_n_o && !adc_cs_n_o));

   assert_hi_nibble_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!adc_wr_n_o && adc_hben_o) |-> (adc_data_o[DATA_W-1:HI_BITS] == '0));

endmodule

bind adc_byte_reader adc_rdr_checks #(
   .DATA_W (DATA_W),
   .RES_W  (RES_W),
   .ID_W   (ID_W)
) u_rdr_checks (
   .clk            (clk),
   .rst_n          (rst_n),
   .adc_busy_i     (adc_busy_i),
   .adc_data_o     (adc_data_o),
   .adc_data_oe_o  (adc_data_oe_o),
   .adc_cs_n_o     (adc_cs_n_o),
   .adc_rd_n_o     (adc_rd_n_o),
   .adc_wr_n_o     (adc_wr_n_o),
   .adc_convst_n_o (adc_convst_n_o),
   .adc_hben_o     (adc_hben_o),
   .result_o       (result_o),
   .chan_o         (chan_o),
   .valid_o        (valid_o),
   .rsv_err_o      (rsv_err_o),
   .timeout_o      (timeout_o)
);

// File: tb/tb_adc_byte_reader.sv
`timescale 1ns/1ps
module tb_adc_byte_reader;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        cfg_wr_i = 1'b0;
   logic [11:0] cfg_word_i = '0;
   logic [5:0]  strobe_len_i = 6'd1;
   logic [15:0] busy_limit_i = 16'd200;
   logic        adc_busy_i = 1'b0;
   logic [7:0]  adc_data_i;
   logic [7:0]  adc_data_o;
   logic        adc_data_oe_o, adc_cs_n_o, adc_rd_n_o, adc_wr_n_o;
   logic        adc_convst_n_o, adc_hben_o;
   logic [11:0] result_o;
   logic [1:0]  chan_o;
   logic        valid_o, rsv_err_o, timeout_o;

   always #4 clk = ~clk;

   adc_byte_reader dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_wr_i(cfg_wr_i),
      .cfg_word_i(cfg_word_i), .strobe_len_i(strobe_len_i),
      .busy_limit_i(busy_limit_i), .adc_busy_i(adc_busy_i),
      .adc_data_i(adc_data_i), .adc_data_o(adc_data_o),
      .adc_data_oe_o(adc_data_oe_o), .adc_cs_n_o(adc_cs_n_o),
      .adc_rd_n_o(adc_rd_n_o), .adc_wr_n_o(adc_wr_n_o),
      .adc_convst_n_o(adc_convst_n_o), .adc_hben_o(adc_hben_o),
      .result_o(result_o), .chan_o(chan_o), .valid_o(valid_o),
      .rsv_err_o(rsv_err_o), .timeout_o(timeout_o)
   );

   // Converter model state
   int         busy_mode = 1;   // 0 never rises, 1 normal, 2 stuck high
   int         busy_len  = 4;
   logic [7:0] m_lo = '0, m_hi = '0;
   int         m_st = 0, m_cnt = 0;

   assign adc_data_i = (!adc_cs_n_o && !adc_rd_n_o) ? (adc_hben_o ? m_hi : m_lo) : 8'h5A;

   // Observation log
   int   checks = 0, failures = 0;
   int   conv_falls, cv_run, cv_len, phase, r3_viol, excl_viol;
   int   rd_cnt, rd_run, wr_cnt, wr_run, wr_before_cv, v_cnt, t_cnt;
   int   rd_len_a[4], wr_len_a[4];
   logic rd_hb_a[4], wr_hb_a[4], wr_oe_a[4];
   logic [7:0] wr_dat_a[4];
   logic [11:0] v_res;
   logic [1:0]  v_chan;
   logic        v_err;
   logic prev_cv = 1'b1, prev_rd = 1'b1, prev_wr = 1'b1;

   task automatic clear_log();
      conv_falls = 0; cv_run = 0; cv_len = 0; phase = 0; r3_viol = 0; excl_viol = 0;
      rd_cnt = 0; rd_run = 0; wr_cnt = 0; wr_run = 0; wr_before_cv = -1;
      v_cnt = 0; t_cnt = 0; v_err = 1'b0; v_res = '0; v_chan = '0;
      for (int i = 0; i < 4; i++) begin
         rd_len_a[i] = 0; wr_len_a[i] = 0; rd_hb_a[i] = 1'bx;
         wr_hb_a[i] = 1'bx; wr_oe_a[i] = 1'b0; wr_dat_a[i] = '0;
      end
   endtask

   initial clear_log();

   always @(negedge clk) begin
      if (prev_cv && !adc_convst_n_o) begin
         conv_falls++;
         wr_before_cv = wr_cnt;
         phase = 0;
         if (busy_mode != 0) begin m_st = 1; m_cnt = 3; end
      end else if (m_st == 1) begin
         m_cnt = m_cnt - 1;
         if (m_cnt == 0) begin adc_busy_i = 1'b1; phase = 1; m_st = 2; m_cnt = busy_len; end
      end else if (m_st == 2 && busy_mode == 1) begin
         m_cnt = m_cnt - 1;
         if (m_cnt == 0) begin adc_busy_i = 1'b0; phase = 2; m_st = 0; end
      end
      if (!adc_convst_n_o) cv_run++;
      else if (!prev_cv) begin cv_len = cv_run; cv_run = 0; end
      if (!adc_rd_n_o) begin
         if (phase != 2) r3_viol++;
         if (prev_rd && rd_cnt < 4) rd_hb_a[rd_cnt] = adc_hben_o;
         rd_run++;
      end else if (!prev_rd) begin
         if (rd_cnt < 4) rd_len_a[rd_cnt] = rd_run;
         rd_cnt++; rd_run = 0;
      end
      if (!adc_wr_n_o) begin
         if (prev_wr && wr_cnt < 4) begin
            wr_hb_a[wr_cnt] = adc_hben_o; wr_dat_a[wr_cnt] = adc_data_o;
            wr_oe_a[wr_cnt] = adc_data_oe_o;
         end
         wr_run++;
      end else if (!prev_wr) begin
         if (wr_cnt < 4) wr_len_a[wr_cnt] = wr_run;
         wr_cnt++; wr_run = 0;
      end
      if (!adc_rd_n_o && !adc_wr_n_o) excl_viol++;
      if ((!adc_rd_n_o || !adc_wr_n_o) && adc_cs_n_o) excl_viol++;
      if (valid_o) begin v_cnt++; v_res = result_o; v_chan = chan_o; v_err = rsv_err_o; end
      if (timeout_o) t_cnt++;
      prev_cv = adc_convst_n_o; prev_rd = adc_rd_n_o; prev_wr = adc_wr_n_o;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_txn(input int w, input logic [11:0] res, input logic [1:0] ch,
                          input logic [1:0] rsv, input bit wr, input logic [11:0] cw,
                          input bit restart);
      @(negedge clk); #1;
      clear_log();
      m_lo = res[7:0]; m_hi = {rsv, ch, res[11:8]};
      strobe_len_i = 6'(w); cfg_wr_i = wr; cfg_word_i = cw; start_i = 1'b1;
      @(negedge clk); #1;
      start_i = 1'b0; cfg_wr_i = 1'b0; cfg_word_i = 12'hFFF; strobe_len_i = 6'd9;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk); #1;
         if (restart && (i == 6 || i == 14)) start_i = 1'b1; else start_i = 1'b0;
         if (v_cnt != 0 || t_cnt != 0) break;
      end
      start_i = 1'b0;
      repeat (6) @(negedge clk);
      #1;
   endtask

   task automatic check_normal(input int w, input logic [11:0] res, input logic [1:0] ch,
                               input bit wr, input logic [11:0] cw, input bit exp_err);
      int ew;
      ew = (w == 0) ? 1 : w;
      check(v_cnt == 1, "R6 valid pulses", v_cnt, 1);
      check(t_cnt == 0, "R8 no timeout", t_cnt, 0);
      check(v_res == res, "R5 result", v_res, res);
      check(v_chan == ch, "R5 channel", v_chan, ch);
      check(v_err == exp_err, "R7 reserved error", v_err, exp_err);
      check(result_o == res, "R6 result held", result_o, res);
      check(cv_len == ew, "R2 convst width", cv_len, ew);
      check(conv_falls == 1, "R10 one convst", conv_falls, 1);
      check(r3_viol == 0, "R3 read before busy done", r3_viol, 0);
      check(rd_cnt == 2, "R4 read count", rd_cnt, 2);
      check(rd_hb_a[0] == 1'b0 && rd_hb_a[1] == 1'b1, "R4 read order", rd_hb_a[0], 0);
      check(rd_len_a[0] == ew && rd_len_a[1] == ew, "R4 read width", rd_len_a[0], ew);
      check(excl_viol == 0, "R11 strobe overlap", excl_viol, 0);
      if (wr) begin
         check(wr_before_cv == 2 && wr_cnt == 2, "R9 writes before convst", wr_before_cv, 2);
         check(wr_dat_a[0] == cw[7:0] && wr_hb_a[0] == 1'b0 && wr_oe_a[0], "R9 low write", wr_dat_a[0], cw[7:0]);
         check(wr_dat_a[1] == {4'h0, cw[11:8]} && wr_hb_a[1] == 1'b1 && wr_oe_a[1], "R9 high write", wr_dat_a[1], {4'h0, cw[11:8]});
         check(wr_len_a[0] == ew && wr_len_a[1] == ew, "R9 write width", wr_len_a[0], ew);
      end else begin
         check(wr_cnt == 0, "R9 no write", wr_cnt, 0);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      logic [11:0] res, prev;
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state
      check(adc_convst_n_o && adc_cs_n_o && adc_rd_n_o && adc_wr_n_o, "R1 strobes idle", 0, 1);
      check(!adc_hben_o && !adc_data_oe_o, "R1 hben/drive low", adc_hben_o, 0);
      check(!valid_o && !rsv_err_o && !timeout_o, "R1 flags low", valid_o, 0);
      check(result_o == 0 && chan_o == 0, "R1 outputs zero", result_o, 0);

      // Sweep: strobe widths 0..4, sixteen result/channel patterns
      for (int w = 0; w <= 4; w++) begin
         for (int k = 0; k < 16; k++) begin
            res = 12'((k * 1093 + w * 7) & 12'hFFF);
            busy_len = 2 + (k % 5);
            run_txn(w, res, 2'(k % 4), 2'b00, (k % 4) == 3, 12'(k * 257 + w), 1'b0);
            check_normal(w, res, 2'(k % 4), (k % 4) == 3, 12'(k * 257 + w), 1'b0);
         end
      end

      // R7 reserved bits nonzero
      for (int r = 1; r < 4; r++) begin
         res = 12'(12'h9C3 + r);
         run_txn(2, res, 2'(r), 2'(r), 1'b0, 12'h0, 1'b0);
         check_normal(2, res, 2'(r), 1'b0, 12'h0, 1'b1);
      end

      // R10 extra starts mid-transaction
      busy_len = 6;
      run_txn(3, 12'h5A7, 2'd2, 2'b00, 1'b1, 12'hABC, 1'b1);
      check_normal(3, 12'h5A7, 2'd2, 1'b1, 12'hABC, 1'b0);

      // R8 timeout: busy never rises, then stuck high
      prev = result_o;
      busy_limit_i = 16'd30;
      for (int mode = 0; mode <= 2; mode += 2) begin
         busy_mode = mode;
         run_txn(2, 12'h123, 2'd1, 2'b00, 1'b0, 12'h0, 1'b0);
         check(t_cnt == 1, "R8 timeout pulse", t_cnt, 1);
         check(v_cnt == 0, "R8 no valid", v_cnt, 0);
         check(rd_cnt == 0, "R8 no read", rd_cnt, 0);
         check(result_o == prev, "R8 result held", result_o, prev);
         @(negedge clk); #1;
         adc_busy_i = 1'b0; m_st = 0;
         repeat (5) @(negedge clk);
      end

      // Recovery after timeout
      busy_mode = 1; busy_limit_i = 16'd200; busy_len = 3;
      run_txn(1, 12'hE0F, 2'd3, 2'b00, 1'b0, 12'h0, 1'b0);
      check_normal(1, 12'hE0F, 2'd3, 1'b0, 12'h0, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule